// File: doc/BRIEF.md
# Diode Emulation Mode Controller

This block chooses, once per switching pulse, how the low-side switch of a synchronous buck stage is used. In continuous conduction the low-side switch always acts as a synchronous rectifier. In diode emulation it is allowed to stay off, so current flowing back from the inductor into it is blocked. A configuration level can pin the stage to continuous conduction. While that level is low, the modulator sends a one-clock pulse strobe on each switching pulse. With that strobe comes a polarity sample of the switch node, taken while the low-side gate is on. A positive sample shows reverse inductor current.

Diode emulation begins only after an unbroken run of positive samples. A single negative sample ends it on the pulse where it is seen. While in emulation, a window-step select tells the modulator to widen its comparator window by a fixed step, and that lowers the switching frequency. An audio-clamp timer runs from the last pulse. If it expires during emulation, it asks the modulator for a forced pulse, which keeps the switching frequency above the audible band.

Top module: `dem_mode_ctrl`

## Requirements
- R1: After reset `dem_o` is 0, `ls_permit_o` is 1, `win_step_o` is 0 and `audio_req_o` is 0.
- R2: While `force_ccm_i` is 1 at a clock edge, `dem_o` is 0 after that edge and the run of positive samples is cleared, whether or not `pulse_i` is high.
- R3: With `force_ccm_i` at 0, `dem_o` becomes 1 on the clock edge that samples the RUN_LEN-th consecutive strobe (`pulse_i`=1) with `sw_pos_i`=1 (1 = switch node positive). RUN_LEN-1 such strobes leave it at 0.
- R4: A strobe with `sw_pos_i`=0 restarts the run, so RUN_LEN further positive strobes are needed to enter.
- R5: In diode emulation, a strobe with `sw_pos_i`=0 clears `dem_o` at that same clock edge, so the next cycle is in continuous conduction.
- R6: `ls_permit_o` is 1 in continuous conduction and 0 in diode emulation.
- R7: `win_step_o` equals `dem_o` on every cycle.
- R8: `audio_req_o` is 1 when `dem_o` is 1 and AUDIO_LIMIT or more clock edges have passed since the last strobe. A strobe clears it at its edge, and it stays 0 in continuous conduction.
- R9: On cycles without a strobe, `sw_pos_i` has no effect on the mode or on the run of positive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| force_ccm_i | input | 1 | 1 = continuous conduction forced |
| pulse_i | input | 1 | One-cycle strobe per switching pulse |
| sw_pos_i | input | 1 | Switch-node polarity sample, 1 = positive |
| dem_o | output | 1 | 1 = diode emulation mode |
| ls_permit_o | output | 1 | 1 = low-side switch permitted to conduct |
| win_step_o | output | 1 | 1 = widen modulator window by the fixed step |
| audio_req_o | output | 1 | Request for a forced pulse from the audio clamp |

## Verification
The bench targets the run boundary. A run of one sample short of the required length must not enter emulation, and a design that is off by one would enter there. A run broken by a negative sample must start over from zero, and a design that only pauses its counter would enter early. The bench also toggles the polarity input on cycles without a strobe, which catches a design that samples polarity on every clock. It holds the stage idle past the clamp limit in both modes, which catches a clamp that fires in continuous conduction or that fails to restart on a strobe.

// File: rtl/dem_pkg.sv
package dem_pkg;
   typedef enum logic {MODE_CCM = 1'b0, MODE_DEM = 1'b1} mode_e;
endpackage

// File: rtl/dem_run_counter.sv
module dem_run_counter #(
   parameter int RUN_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   input  logic pos_i,
   input  logic force_i,
   output logic qualify_o
);
   localparam int CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
   localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (force_i) begin
         run_q <= '0;
      end else if (pulse_i) begin
         if (!pos_i)            run_q <= '0;
         else if (run_q != FULL) run_q <= run_q + 1'b1;
      end
   end

   assign qualify_o = pulse_i & pos_i & ~force_i & (run_q >= LAST);

   // R4: a negative strobe empties the run
   p_run_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && !pos_i) |=> (run_q == '0));
   // R2: forcing continuous conduction empties the run
   p_run_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
      force_i |=> (run_q == '0));
endmodule

// File: rtl/dem_mode_fsm.sv
module dem_mode_fsm
   import dem_pkg::*;
#(
   parameter bit WIN_STEP_REG = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  force_i,
   input  logic  pulse_i,
   input  logic  pos_i,
   input  logic  qualify_i,
   output mode_e mode_o,
   output logic  win_step_o
);
   mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (force_i)                 mode_d = MODE_CCM;
      else if (pulse_i && !pos_i)  mode_d = MODE_CCM;
      else if (qualify_i)          mode_d = MODE_DEM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_CCM;
      else        mode_q <= mode_d;
   end

   assign mode_o = mode_q;

   generate
      if (WIN_STEP_REG) begin : g_win_reg
         logic step_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) step_q <= 1'b0;
            else        step_q <= (mode_d == MODE_DEM);
         end
         assign win_step_o = step_q;
      end else begin : g_win_comb
         assign win_step_o = (mode_q == MODE_DEM);
      end
   endgenerate

   // R2: forced continuous conduction leaves emulation
   p_forced_ccm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      force_i |=> (mode_o == MODE_CCM));
   // R5: negative strobe exits at once
   p_exit_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && !pos_i) |=> (mode_o == MODE_CCM));
   // R3: entry only on a qualifying strobe
   p_entry_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_o == MODE_DEM) |-> $past(qualify_i));
   // R9: no strobe, no force, no mode change
   p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_i && !force_i) |=> $stable(mode_o));
   // R7: window step follows the mode
   p_win_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_step_o == (mode_o == MODE_DEM));
endmodule

// File: rtl/dem_audio_timer.sv
module dem_audio_timer #(
   parameter int LIMIT = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   input  logic dem_i,
   output logic req_o
);
   localparam int TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] TOP = TW'(LIMIT);

   logic [TW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= '0;
      else if (pulse_i)       age_q <= '0;
      else if (age_q != TOP)  age_q <= age_q + 1'b1;
   end

   assign req_o = dem_i & (age_q == TOP);

   // R8: a strobe restarts the clamp timer
   p_req_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_i |=> !req_o);
endmodule

// File: rtl/dem_mode_ctrl.sv
module dem_mode_ctrl
   import dem_pkg::*;
#(
   parameter int RUN_LEN      = 8,
   parameter int AUDIO_LIMIT  = 2000,
   parameter bit WIN_STEP_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_ccm_i,
   input  logic pulse_i,
   input  logic sw_pos_i,
   output logic dem_o,
   output logic ls_permit_o,
   output logic win_step_o,
   output logic audio_req_o
);
   generate
      if (RUN_LEN < 1) begin : g_bad_run
         $error("RUN_LEN must be at least 1");
      end
      if (AUDIO_LIMIT < 2) begin : g_bad_limit
         $error("AUDIO_LIMIT must be at least 2");
      end
   endgenerate

   logic  qualify;
   mode_e mode;

   dem_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
      .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .pos_i(sw_pos_i),
      .force_i(force_ccm_i), .qualify_o(qualify)
   );

   dem_mode_fsm #(.WIN_STEP_REG(WIN_STEP_REG)) u_fsm (
      .clk(clk), .rst_n(rst_n), .force_i(force_ccm_i), .pulse_i(pulse_i),
      .pos_i(sw_pos_i), .qualify_i(qualify), .mode_o(mode),
      .win_step_o(win_step_o)
   );

   assign dem_o       = (mode == MODE_DEM);
   assign ls_permit_o = ~dem_o;

   dem_audio_timer #(.LIMIT(AUDIO_LIMIT)) u_aud (
      .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .dem_i(dem_o),
      .req_o(audio_req_o)
   );

   // R8: clamp request only in emulation
   p_audio_dem_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      audio_req_o |-> win_step_o);
endmodule

// File: tb/dem_mode_ctrl_tb.sv
module dem_mode_ctrl_tb;
   localparam int RUN = 8;
   localparam int LIM = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic force_ccm_i = 1'b0, pulse_i = 1'b0, sw_pos_i = 1'b0;
   logic dem_o, ls_permit_o, win_step_o, audio_req_o;

   always #10 clk = ~clk;

   dem_mode_ctrl #(.RUN_LEN(RUN), .AUDIO_LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .force_ccm_i(force_ccm_i), .pulse_i(pulse_i),
      .sw_pos_i(sw_pos_i), .dem_o(dem_o), .ls_permit_o(ls_permit_o),
      .win_step_o(win_step_o), .audio_req_o(audio_req_o)
   );

   typedef struct {
      logic  dem, permit, win, aud;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0, errors = 0;
   int m_run = 0, m_age = 0;
   logic m_dem = 1'b0;

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {dem,permit,win,aud} actual %b expected %b", tag, act, exp);
      end
   endtask

   // monitor: pops expected items and compares away from the active edge
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, {dem_o, ls_permit_o, win_step_o, audio_req_o},
               {e.dem, e.permit, e.win, e.aud});
      end
   end

   // driver: drives one cycle and pushes the expected result after the edge
   task automatic step(input logic p, input logic pos, input logic f, input string tag);
      exp_t e;
      @(negedge clk);
      pulse_i = p; sw_pos_i = pos; force_ccm_i = f;
      if (f) begin
         m_dem = 1'b0; m_run = 0;
      end else if (p) begin
         if (!pos) begin m_run = 0; m_dem = 1'b0; end
         else begin
            if (m_run < RUN) m_run++;
            if (m_run >= RUN) m_dem = 1'b1;
         end
      end
      if (p) m_age = 0; else if (m_age < LIM) m_age++;
      e.dem = m_dem; e.permit = ~m_dem; e.win = m_dem;
      e.aud = m_dem && (m_age == LIM);
      e.tag = tag;
      @(posedge clk);
      q.push_back(e);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", {dem_o, ls_permit_o, win_step_o, audio_req_o}, 4'b0100);
      rst_n = 1'b1;
      // R3: one short of the run stays in continuous conduction
      for (int i = 0; i < RUN - 1; i++) begin
         step(1, 1, 0, "R3 short run");
         step(0, 0, 0, "R3 short run gap");
      end
      // R9: polarity toggles without a strobe are ignored
      step(0, 0, 0, "R9 idle neg"); step(0, 1, 0, "R9 idle pos");
      step(1, 1, 0, "R3 entry on last pulse R6 R7");
      step(0, 1, 0, "R7 hold");
      // R9 in emulation: negative polarity without a strobe
      step(0, 0, 0, "R9 no strobe in emulation");
      step(0, 0, 0, "R9 no strobe in emulation");
      step(1, 0, 0, "R5 exit on negative strobe");
      step(0, 0, 0, "R5 stays continuous");
      // R4: broken run restarts
      for (int i = 0; i < 5; i++) step(1, 1, 0, "R4 partial run");
      step(1, 0, 0, "R4 break");
      for (int i = 0; i < RUN - 1; i++) step(1, 1, 0, "R4 restart not enough");
      step(1, 1, 0, "R4 restart enters");
      // R8: clamp timer in emulation
      for (int i = 0; i < LIM + 5; i++) step(0, 0, 0, "R8 idle in emulation");
      step(1, 1, 0, "R8 strobe clears request");
      for (int i = 0; i < 10; i++) step(0, 0, 0, "R8 restarted timer");
      // R2: force exits without a strobe
      step(0, 0, 1, "R2 force exits");
      for (int i = 0; i < RUN + 2; i++) step(1, 1, 1, "R2 forced run ignored");
      for (int i = 0; i < LIM + 5; i++) step(0, 0, 1, "R8 no request in continuous");
      for (int i = 0; i < RUN - 1; i++) step(1, 1, 0, "R2 count cleared by force");
      step(0, 0, 1, "R2 force mid run");
      for (int i = 0; i < RUN - 1; i++) step(1, 1, 0, "R2 run restarted after force");
      step(1, 1, 0, "R3 entry after force release");
      step(0, 0, 0, "R6 permit low");
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule